// File: doc/BRIEF.md
# Masked Ternary Match Table

This block is a small associative lookup table. It holds a fixed number of data words, 16 by default, each 32 bits wide. A write port loads one word at a chosen index. A clear command sets every word to zero. A search request carries a key and a per-entry force mask. The block compares the key with every stored word at once and returns three things: a hit flag, a vector with one bit for each matching entry, and the index of the winning match. Any entry whose bit is set in the force mask counts as a match, whatever it holds. When more than one entry matches, the highest index wins.

Searches enter through a valid/ready request channel and leave through a valid/ready result channel. The result register holds one result. A request is accepted on a clock edge only when that register is empty or is being read on the same edge, so `srch_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, the result stays unchanged and new requests wait. The write and clear pins are plain control pins with no handshake.

Top module: `mtt_table`

## Requirements
- R1: With `wr_en` high and `clr` low at a clock edge, `wr_data` is stored in the entry whose index is `wr_addr`.
- R2: An entry matches a search when its stored word equals `srch_key`.
- R3: An entry also matches when its bit in `srch_mask` is 1, whatever it holds.
- R4: Bit i of `res_vec` is 1 exactly when entry i matches.
- R5: `res_hit` is 1 when at least one entry matches, and 0 otherwise.
- R6: When several entries match, `res_idx` is the highest matching index.
- R7: When nothing matches, `res_vec` and `res_idx` are both zero.
- R8: With `clr` high at a clock edge, every entry becomes zero. A load in the same cycle is discarded.
- R9: A search accepted on the same edge as a load or a clear compares against the contents from before that edge.
- R10: A search accepted at a clock edge gives its result on `res_valid` and the result pins right after that edge. While `res_ready` is low the result holds steady, and `srch_ready` is `!res_valid || res_ready`.
- R11: After reset, `res_valid` is 0 and every entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load strobe |
| wr_addr | input | 4 | Entry index to load |
| wr_data | input | 32 | Word to load |
| clr | input | 1 | Zero all entries; wins over a load |
| srch_valid | input | 1 | Search request present |
| srch_ready | output | 1 | Search request can be accepted |
| srch_key | input | 32 | Word to compare against every entry |
| srch_mask | input | 16 | Per-entry force-match bits |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_hit | output | 1 | At least one entry matched |
| res_vec | output | 16 | One bit per matching entry |
| res_idx | output | 4 | Highest matching index, 0 when no hit |

## Verification
The table is filled with a known pattern that has one duplicated word, a long run of zero entries and one distinct word in the top slot. Searches are then run against it. A single exact hit shows that the comparator works. The duplicated word and the zero run show that the highest match wins. A missing key shows the zeroed outputs on a miss. Keys combined with partial or full force masks separate the mask path from the equality path. Directed sequences place a load or a clear on the same edge as a search, and a clear together with a load. They also stall the result channel to show that the result holds and the request waits.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

  // Storage command decoded from the write-side pins.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WIPE  = 2'd2
  } store_op_e;

  function automatic store_op_e decode_store_op(input logic wipe, input logic load);
    if (wipe)      return ST_WIPE;
    else if (load) return ST_LOAD;
    else           return ST_IDLE;
  endfunction

endpackage

// File: rtl/mtt_store.sv
module mtt_store #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic                           wipe,
  input  logic [IDX_W-1:0]               load_idx,
  input  logic [WIDTH-1:0]               load_word,
  output logic [ENTRIES-1:0][WIDTH-1:0]  words
);
  import mtt_pkg::*;

  store_op_e op;
  assign op = decode_store_op(wipe, load);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = (load_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else begin
        unique case (op)
          ST_WIPE: words[g] <= '0;
          ST_LOAD: if (sel) words[g] <= load_word;
          default: ;
        endcase
      end
    end
  end

  // R8: a clear leaves every slot zero on the next cycle
  p_wipe_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (words == '0));

  // R1: a load without clear lands in the addressed slot
  p_load_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wipe) |=> (words[$past(load_idx)] == $past(load_word)));

endmodule

// File: rtl/mtt_compare.sv
module mtt_compare #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 32
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] words,
  input  logic [WIDTH-1:0]              key,
  input  logic [ENTRIES-1:0]            force_mask,
  output logic [ENTRIES-1:0]            hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic eq;
    assign eq      = (words[g] == key);
    assign hits[g] = eq | force_mask[g];
  end
endmodule

// File: rtl/mtt_prio.sv
module mtt_prio #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   top_idx
);
  // Ascending scan: later (higher) hits overwrite earlier ones.
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i]) top_idx = IDX_W'(i);
    end
  end

  assign any = |hits;
endmodule

// File: rtl/mtt_table.sv
module mtt_table #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               clr,
  input  logic               srch_valid,
  output logic               srch_ready,
  input  logic [WIDTH-1:0]   srch_key,
  input  logic [ENTRIES-1:0] srch_mask,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_hit,
  output logic [ENTRIES-1:0] res_vec,
  output logic [IDX_W-1:0]   res_idx
);
  logic [ENTRIES-1:0][WIDTH-1:0] words;
  logic [ENTRIES-1:0]            hits;
  logic                          any;
  logic [IDX_W-1:0]              top_idx;
  logic                          take;

  mtt_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_en),
    .wipe      (clr),
    .load_idx  (wr_addr),
    .load_word (wr_data),
    .words     (words)
  );

  mtt_compare #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_cmp (
    .words      (words),
    .key        (srch_key),
    .force_mask (srch_mask),
    .hits       (hits)
  );

  mtt_prio #(.ENTRIES(ENTRIES)) u_prio (
    .hits    (hits),
    .any     (any),
    .top_idx (top_idx)
  );

  assign srch_ready = !res_valid || res_ready;
  assign take       = srch_valid && srch_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_vec   <= '0;
      res_idx   <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_hit   <= any;
      res_vec   <= hits;
      res_idx   <= top_idx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R5: hit flag agrees with the vector
  p_hit_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_vec != '0)));

  // R7: a miss reports index zero
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0));

  // R6: winning index is a set bit with none above it
  p_top_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_vec[res_idx] && ((res_vec >> res_idx) == 1)));

  // R3: an all-ones mask makes every entry match
  p_full_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (srch_mask == '1)) |=> (res_vec == '1));

  // R10: a stalled result holds
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_vec) && $stable(res_idx)
                                   && $stable(res_hit)));

  // R10: an accepted search yields a result next cycle
  p_take_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);

endmodule

// File: tb/test_mtt_table.sv
module test_mtt_table;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        clr = 1'b0;
  logic        srch_valid = 1'b0;
  logic        srch_ready;
  logic [31:0] srch_key = '0;
  logic [15:0] srch_mask = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [15:0] res_vec;
  logic [3:0]  res_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtt_table i_mtt_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr(clr), .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_key(srch_key),
    .srch_mask(srch_mask), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_vec(res_vec), .res_idx(res_idx)
  );

  // Vector table over contents e0=10 e1=20 e2=25 e3=30 e4=20 e15=A5A50F0F, rest 0.
  localparam logic [31:0] V_KEY  [NV] = '{32'd20, 32'd25, 32'd99, 32'd99,
                                          32'd10, 32'd0, 32'hA5A5_0F0F, 32'd30};
  localparam logic [15:0] V_MASK [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0009,
                                          16'h0100, 16'h0000, 16'h0000, 16'hFFFF};
  localparam logic        V_HIT  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [15:0] V_VEC  [NV] = '{16'h0012, 16'h0004, 16'h0000, 16'h0009,
                                          16'h0101, 16'h7FE0, 16'h8000, 16'hFFFF};
  localparam logic [3:0]  V_IDX  [NV] = '{4'd4, 4'd2, 4'd0, 4'd3, 4'd8, 4'd14, 4'd15, 4'd15};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic search(input logic [31:0] k, input logic [15:0] m);
    @(negedge clk);
    res_ready = 1'b1; srch_valid = 1'b1; srch_key = k; srch_mask = m;
    @(negedge clk);
    srch_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic h, input logic [15:0] v,
                            input logic [3:0] ix);
    chk({req, " valid"}, 32'(res_valid), 32'd1);
    chk({req, " hit"}, 32'(res_hit), 32'(h));
    chk({req, " vec"}, 32'(res_vec), 32'(v));
    chk({req, " idx"}, 32'(res_idx), 32'(ix));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 res_valid", 32'(res_valid), 32'd0);
    chk("R11 srch_ready", 32'(srch_ready), 32'd1);
    rst_n = 1'b1;
    // R11: all entries zero -> key 0 matches all, top wins 15
    search(32'd0, 16'h0000);
    expect_res("R11 zero contents", 1'b1, 16'hFFFF, 4'd15);

    // R1: fill
    load(4'd0, 32'd10);
    load(4'd1, 32'd20);
    load(4'd2, 32'd25);
    load(4'd3, 32'd30);
    load(4'd4, 32'd20);
    load(4'd15, 32'hA5A5_0F0F);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < NV; i++) begin
      search(V_KEY[i], V_MASK[i]);
      expect_res($sformatf("R2/R3/R4/R6/R7 vec%0d", i), V_HIT[i], V_VEC[i], V_IDX[i]);
    end
    // R5: miss clears hit
    search(32'd12345, 16'h0000);
    chk("R5 miss hit", 32'(res_hit), 32'd0);
    chk("R7 miss idx", 32'(res_idx), 32'd0);

    // R9: load and search on same edge see old contents
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'd77;
    srch_valid = 1'b1; srch_key = 32'd77; srch_mask = '0;
    @(negedge clk);
    wr_en = 1'b0; srch_valid = 1'b0;
    chk("R9 same-cycle hit", 32'(res_hit), 32'd0);
    search(32'd77, 16'h0000);
    expect_res("R1 R9 after load", 1'b1, 16'h0008, 4'd3);

    // R10: back-pressure
    @(negedge clk);
    res_ready = 1'b0; srch_valid = 1'b1; srch_key = 32'd20; srch_mask = '0;
    @(negedge clk);
    chk("R10 valid", 32'(res_valid), 32'd1);
    chk("R10 srch_ready low", 32'(srch_ready), 32'd0);
    srch_key = 32'd99; srch_mask = 16'hFFFF;
    @(negedge clk);
    chk("R10 held vec", 32'(res_vec), 32'h0012);
    chk("R10 held idx", 32'(res_idx), 32'd4);
    res_ready = 1'b1;
    @(negedge clk);
    srch_valid = 1'b0;
    chk("R10 next vec", 32'(res_vec), 32'hFFFF);
    chk("R10 next idx", 32'(res_idx), 32'd15);
    @(negedge clk);
    chk("R10 drained", 32'(res_valid), 32'd0);

    // R8 R9: clear with same-cycle load and search
    @(negedge clk);
    clr = 1'b1; wr_en = 1'b1; wr_addr = 4'd2; wr_data = 32'd55;
    srch_valid = 1'b1; srch_key = 32'd25; srch_mask = '0;
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0; srch_valid = 1'b0;
    expect_res("R9 search during clear", 1'b1, 16'h0004, 4'd2);
    search(32'd0, 16'h0000);
    expect_res("R8 cleared", 1'b1, 16'hFFFF, 4'd15);
    search(32'd55, 16'h0000);
    chk("R8 load dropped", 32'(res_hit), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule